// File: doc/BRIEF.md
# Per-Channel Clock Blocking Generator

This block produces two gating strobes for a 32-timeslot TDM frame, one that follows the receive timeslot timing and one that follows the transmit timing. During any channel whose mask bit is set, the strobe is held high for that whole channel time. A downstream HDLC or serial controller can use the strobe to suppress its clock in channels it must not handle. Each direction owns four byte-wide mask registers, and software reaches them over a simple byte-addressed register bus.

Each direction has its own timeslot counter. A per-direction bit strobe advances it, and a frame sync aligns it. Each channel lasts eight bit strobes. A mode bit in a separate control register gives the transmit masks a second meaning. When the mode bit is set, the transmit mask bit of the current channel is also presented as a signaling-source select, where 1 means the internal signaling registers and 0 means the serial stream.

Top module: `chan_blk_gen`

## Requirements
- R1: After reset every mask register and the control register read as 0, and `rx_gate`, `tx_gate` and `tx_sig_from_reg` are low.
- R2: Receive masks are at byte addresses 0x2B..0x2E and transmit masks are at 0x22..0x25, with the lowest channel group at the lowest address. The mode flag is bit 6 of the control register at 0x30, and the other control bits read 0. Any other address reads 0. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R3: Bit b of the mask register at offset k (k = 0..3) controls channel 8k+b+1, so offset 0 bit 0 is channel 1 and offset 3 bit 7 is channel 32.
- R4: `rx_gate` is high for the whole of a receive channel whose receive mask bit is 1 and low for the whole of a channel whose bit is 0. It changes only on the first bit strobe of a channel.
- R5: `tx_gate` behaves like `rx_gate`, but it uses the transmit masks and the transmit timing.
- R6: A bit strobe with frame sync high is bit 1 of channel 1. A channel lasts 8 bit strobes. Without sync, channel 32 is followed by channel 1. After reset, the first bit strobe without sync starts channel 1. Cycles without a bit strobe leave the timing and the outputs unchanged.
- R7: The receive output depends only on the receive masks and the receive strobes, and the transmit output depends only on the transmit masks and the transmit strobes.
- R8: `tx_sig_from_reg` equals the transmit mask bit of the current transmit channel while the mode flag is 1, and it is 0 while the mode flag is 0.
- R9: A register write made in the middle of a channel leaves the outputs of that channel unchanged. The new value takes effect from the next channel start of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| rx_bit_en | input | 1 | Receive bit strobe, one per bit time |
| rx_fsync | input | 1 | Receive frame sync, qualified by `rx_bit_en` |
| tx_bit_en | input | 1 | Transmit bit strobe, one per bit time |
| tx_fsync | input | 1 | Transmit frame sync, qualified by `tx_bit_en` |
| rx_gate | output | 1 | Receive channel gating strobe |
| tx_gate | output | 1 | Transmit channel gating strobe |
| tx_sig_from_reg | output | 1 | Signaling source select for the current transmit channel |

## Verification
The bench builds the block with its default values: 32 channels, 8 bits per channel and byte-wide registers. This lets one run cover all four register offsets in each direction, the wrap from channel 32 back to channel 1, and both ends of every register byte. Running the receive and transmit timing with frame syncs placed apart exposes any leak between the two lanes. Writes made in the middle of a channel show whether a new value waits for the next channel start.

// File: rtl/chblk_pkg.sv
`timescale 1ns/1ps
package chblk_pkg;

  localparam int DEF_NUM_CH = 32;
  localparam int DEF_BIT_PER_CH = 8;
  localparam int DEF_AW = 8;
  localparam int DEF_DW = 8;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RX   = 2'd1,
    RG_TX   = 2'd2,
    RG_CTRL = 2'd3
  } reg_region_e;

endpackage

// File: rtl/chblk_regs.sv
`timescale 1ns/1ps
module chblk_regs
  import chblk_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int AW = DEF_AW,
  parameter int DW = DEF_DW,
  parameter int unsigned RX_BASE = 'h2B,
  parameter int unsigned TX_BASE = 'h22,
  parameter int unsigned CTRL_ADDR = 'h30,
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NUM_CH-1:0] rx_mask,
  output logic [NUM_CH-1:0] tx_mask,
  output logic              mode
);

  localparam int NUM_REGS = NUM_CH / DW;
  localparam int SLOT_W = $clog2(2 * NUM_REGS);
  localparam logic [AW-1:0] RX_LO = AW'(RX_BASE);
  localparam logic [AW-1:0] RX_HI = AW'(RX_BASE + NUM_REGS - 1);
  localparam logic [AW-1:0] TX_LO = AW'(TX_BASE);
  localparam logic [AW-1:0] TX_HI = AW'(TX_BASE + NUM_REGS - 1);
  localparam logic [AW-1:0] CT_AD = AW'(CTRL_ADDR);

  logic [DW-1:0] mem_q [2*NUM_REGS];
  logic          mode_q;
  reg_region_e   region;
  logic [SLOT_W-1:0] slot;
  logic [DW-1:0] ctrl_val;

  // address decode: which bank and which byte within it
  always_comb begin
    region = RG_NONE;
    slot = '0;
    if (addr >= RX_LO && addr <= RX_HI) begin
      region = RG_RX;
      slot = SLOT_W'(addr - RX_LO);
    end else if (addr >= TX_LO && addr <= TX_HI) begin
      region = RG_TX;
      slot = SLOT_W'(NUM_REGS) + SLOT_W'(addr - TX_LO);
    end else if (addr == CT_AD) begin
      region = RG_CTRL;
    end
  end

  always_comb begin
    ctrl_val = '0;
    ctrl_val[MODE_BIT] = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2*NUM_REGS; i++) mem_q[i] <= '0;
      mode_q <= 1'b0;
    end else if (wr) begin
      case (region)
        RG_RX, RG_TX: mem_q[slot] <= wdata;
        RG_CTRL:      mode_q <= wdata[MODE_BIT];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (region)
        RG_RX, RG_TX: rdata <= mem_q[slot];
        RG_CTRL:      rdata <= ctrl_val;
        default:      rdata <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_map
    assign rx_mask[g*DW +: DW] = mem_q[g];
    assign tx_mask[g*DW +: DW] = mem_q[NUM_REGS + g];
  end

  assign mode = mode_q;

endmodule

// File: rtl/chblk_slot_cnt.sv
`timescale 1ns/1ps
module chblk_slot_cnt
  import chblk_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int BIT_PER_CH = DEF_BIT_PER_CH,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int BIT_W = $clog2(BIT_PER_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            fsync,
  output logic            start,
  output logic [CH_W-1:0] next_ch
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BIT_PER_CH - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CH_W-1:0]  ch_q, ch_d;

  always_comb begin
    if (fsync) begin
      bit_d = '0;
      ch_d  = '0;
    end else if (bit_q == BIT_LAST) begin
      bit_d = '0;
      ch_d  = (ch_q == CH_LAST) ? '0 : ch_q + CH_W'(1);
    end else begin
      bit_d = bit_q + BIT_W'(1);
      ch_d  = ch_q;
    end
  end

  // reset parks on the last bit of the last channel so the first strobe opens channel 1
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= BIT_LAST;
      ch_q  <= CH_LAST;
    end else if (bit_en) begin
      bit_q <= bit_d;
      ch_q  <= ch_d;
    end
  end

  assign start   = bit_en && (bit_d == '0);
  assign next_ch = ch_d;

endmodule

// File: rtl/chblk_gate_out.sv
`timescale 1ns/1ps
module chblk_gate_out
  import chblk_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             start,
  input  logic [1:0][CH_W-1:0]   next_ch,
  input  logic [1:0][NUM_CH-1:0] mask,
  input  logic                   mode,
  output logic [1:0]             gate,
  output logic                   sig_sel
);

  // lane 0 = receive, lane 1 = transmit
  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (start[g]) gate[g] <= mask[g][next_ch[g]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_sel <= 1'b0;
    end else if (start[1]) begin
      sig_sel <= mode & mask[1][next_ch[1]];
    end
  end

endmodule

// File: rtl/chan_blk_gen.sv
`timescale 1ns/1ps
module chan_blk_gen
  import chblk_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int BIT_PER_CH = DEF_BIT_PER_CH,
  parameter int AW = DEF_AW,
  parameter int DW = DEF_DW,
  parameter int unsigned RX_BASE = 'h2B,
  parameter int unsigned TX_BASE = 'h22,
  parameter int unsigned CTRL_ADDR = 'h30,
  parameter int MODE_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_bit_en,
  input  logic          rx_fsync,
  input  logic          tx_bit_en,
  input  logic          tx_fsync,
  output logic          rx_gate,
  output logic          tx_gate,
  output logic          tx_sig_from_reg
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0]       rx_mask, tx_mask;
  logic                    mode;
  logic [1:0]              bit_en_v, fsync_v, start_v, gate_v;
  logic [1:0][CH_W-1:0]    next_ch_v;
  logic [1:0][NUM_CH-1:0]  mask_v;

  assign bit_en_v = {tx_bit_en, rx_bit_en};
  assign fsync_v  = {tx_fsync, rx_fsync};
  assign mask_v   = {tx_mask, rx_mask};

  chblk_regs #(
    .NUM_CH(NUM_CH), .AW(AW), .DW(DW),
    .RX_BASE(RX_BASE), .TX_BASE(TX_BASE),
    .CTRL_ADDR(CTRL_ADDR), .MODE_BIT(MODE_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .rx_mask(rx_mask), .tx_mask(tx_mask), .mode(mode)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    chblk_slot_cnt #(.NUM_CH(NUM_CH), .BIT_PER_CH(BIT_PER_CH)) u_cnt (
      .clk(clk), .rst(rst),
      .bit_en(bit_en_v[g]), .fsync(fsync_v[g]),
      .start(start_v[g]), .next_ch(next_ch_v[g])
    );
  end

  chblk_gate_out #(.NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst(rst),
    .start(start_v), .next_ch(next_ch_v), .mask(mask_v), .mode(mode),
    .gate(gate_v), .sig_sel(tx_sig_from_reg)
  );

  assign rx_gate = gate_v[0];
  assign tx_gate = gate_v[1];

endmodule

// File: rtl/chblk_checker.sv
`timescale 1ns/1ps
module chblk_checker #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NUM_REGS = 4,
  parameter int unsigned RX_BASE = 'h2B,
  parameter int unsigned TX_BASE = 'h22,
  parameter int unsigned CTRL_ADDR = 'h30
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_bit_en,
  input logic          tx_bit_en,
  input logic          rx_gate,
  input logic          tx_gate,
  input logic          tx_sig_from_reg
);

  logic mapped;
  assign mapped = (int'(bus_addr) >= int'(RX_BASE) && int'(bus_addr) < int'(RX_BASE) + NUM_REGS) ||
                  (int'(bus_addr) >= int'(TX_BASE) && int'(bus_addr) < int'(TX_BASE) + NUM_REGS) ||
                  (int'(bus_addr) == int'(CTRL_ADDR));

  // R1: outputs idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rx_gate && !tx_gate && !tx_sig_from_reg && bus_rdata == '0));

  // R2: unmapped addresses read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  // R4: receive strobe moves only on a receive bit strobe
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !rx_bit_en |=> $stable(rx_gate));

  // R5: transmit strobe moves only on a transmit bit strobe
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_bit_en |=> $stable(tx_gate));

  // R8: register-sourced signaling only in channels whose transmit mask is set
  p_sig_needs_mask_r8: assert property (@(posedge clk) disable iff (rst)
    tx_sig_from_reg |-> tx_gate);

  // R8: signaling select also moves only with transmit timing
  p_sig_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_bit_en |=> $stable(tx_sig_from_reg));

endmodule

bind chan_blk_gen chblk_checker #(
  .AW(AW), .DW(DW), .NUM_REGS(NUM_CH / DW),
  .RX_BASE(RX_BASE), .TX_BASE(TX_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en),
  .rx_gate(rx_gate), .tx_gate(tx_gate), .tx_sig_from_reg(tx_sig_from_reg)
);

// File: tb/sim_chan_blk_gen.sv
`timescale 1ns/1ps
module sim_chan_blk_gen;

  localparam int NCH = 32;
  localparam int BPC = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       rx_bit_en = 0, rx_fsync = 0, tx_bit_en = 0, tx_fsync = 0;
  logic       rx_gate, tx_gate, tx_sig_from_reg;

  chan_blk_gen u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync),
    .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync),
    .rx_gate(rx_gate), .tx_gate(tx_gate), .tx_sig_from_reg(tx_sig_from_reg)
  );

  int checks = 0, errors = 0;

  // reference model built from the requirements
  logic [NCH-1:0] m_rx = '0, m_tx = '0;
  logic           m_mode = 1'b0;
  int rb = BPC-1, rc = NCH-1, tb = BPC-1, tc = NCH-1;
  logic e_rx = 0, e_tx = 0, e_sg = 0;
  string cur_tag = "";

  // scoreboard queues
  logic  q_rx[$], q_tx[$], q_sg[$];
  string q_tag[$];
  logic  due = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a >= 8'h2B && a <= 8'h2E) return m_rx[(a - 8'h2B)*8 +: 8];
    if (a >= 8'h22 && a <= 8'h25) return m_tx[(a - 8'h22)*8 +: 8];
    if (a == 8'h30) return {1'b0, m_mode, 6'b0};
    return 8'h00;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    if (a >= 8'h2B && a <= 8'h2E) m_rx[(a - 8'h2B)*8 +: 8] = d;
    else if (a >= 8'h22 && a <= 8'h25) m_tx[(a - 8'h22)*8 +: 8] = d;
    else if (a == 8'h30) m_mode = d[6];
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
    chk($sformatf("%s read %0h", tag, a), {24'h0, bus_rdata}, {24'h0, model_read(a)});
  endtask

  // driver: one bit time, expected value pushed for the monitor
  task automatic step(input bit rs, input bit ts, input bit ren = 1, input bit ten = 1);
    @(negedge clk);
    rx_bit_en = ren; rx_fsync = rs; tx_bit_en = ten; tx_fsync = ts;
    if (ren) begin
      if (rs) begin rb = 0; rc = 0; end
      else if (rb == BPC-1) begin rb = 0; rc = (rc + 1) % NCH; end
      else rb++;
      if (rb == 0) e_rx = m_rx[rc];
    end
    if (ten) begin
      if (ts) begin tb = 0; tc = 0; end
      else if (tb == BPC-1) begin tb = 0; tc = (tc + 1) % NCH; end
      else tb++;
      if (tb == 0) begin e_tx = m_tx[tc]; e_sg = m_mode & m_tx[tc]; end
    end
    q_rx.push_back(e_rx); q_tx.push_back(e_tx); q_sg.push_back(e_sg);
    q_tag.push_back(cur_tag);
    @(posedge clk); #1;
    rx_bit_en = 0; rx_fsync = 0; tx_bit_en = 0; tx_fsync = 0;
    due = 1;
  endtask

  // monitor: compares one expected item after each driven bit time
  always @(negedge clk) begin
    if (due && q_rx.size() > 0) begin
      logic  xr, xt, xs;
      string tg;
      due = 0;
      xr = q_rx.pop_front(); xt = q_tx.pop_front(); xs = q_sg.pop_front();
      tg = q_tag.pop_front();
      chk({tg, " rx_gate"}, {31'h0, rx_gate}, {31'h0, xr});
      chk({tg, " tx_gate"}, {31'h0, tx_gate}, {31'h0, xt});
      chk({tg, " tx_sig_from_reg"}, {31'h0, tx_sig_from_reg}, {31'h0, xs});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rx_gate", {31'h0, rx_gate}, 0);
    chk("R1 tx_gate", {31'h0, tx_gate}, 0);
    chk("R1 tx_sig_from_reg", {31'h0, tx_sig_from_reg}, 0);
    for (int a = 'h22; a <= 'h2E; a++) bus_read(8'(a), "R1");
    bus_read(8'h30, "R1");

    // R2: register access, unmapped and control bits
    bus_write(8'h2B, 8'h01); bus_write(8'h2C, 8'h80);
    bus_write(8'h2D, 8'h55); bus_write(8'h2E, 8'hC3);
    bus_write(8'h22, 8'hFF); bus_write(8'h23, 8'h00);
    bus_write(8'h24, 8'h0F); bus_write(8'h25, 8'hA5);
    for (int a = 'h21; a <= 'h31; a++) bus_read(8'(a), "R2");
    bus_write(8'h30, 8'hFF);
    bus_read(8'h30, "R2 ctrl");
    bus_write(8'h30, 8'h00);
    bus_read(8'h30, "R2 ctrl");

    // R3 R4 R5: one aligned frame with mixed masks
    cur_tag = "R3 R4 R5 frame";
    step(1, 1);
    repeat (NCH*BPC - 1) step(0, 0);

    // R6: wrap from channel 32 to channel 1 without sync, then idle cycles
    cur_tag = "R6 wrap";
    repeat (NCH*BPC) step(0, 0);
    cur_tag = "R6 idle";
    repeat (24) begin step(0, 0); step(0, 0, 0, 0); end

    // R8: mode flag set, then cleared
    bus_write(8'h30, 8'h40);
    cur_tag = "R8 mode1";
    step(1, 1);
    repeat (NCH*BPC - 1) step(0, 0);
    bus_write(8'h30, 8'h00);
    cur_tag = "R8 mode0";
    step(1, 1);
    repeat (NCH*BPC - 1) step(0, 0);

    // R7: transmit all ones, receive all zeros, offset syncs, transmit-only strobes
    for (int a = 'h22; a <= 'h25; a++) bus_write(8'(a), 8'hFF);
    for (int a = 'h2B; a <= 'h2E; a++) bus_write(8'(a), 8'h00);
    cur_tag = "R7 lanes";
    step(1, 0);
    repeat (39) step(0, 0);
    step(0, 1);
    repeat (300) step(0, 0);
    repeat (40) step(0, 0, 0, 1);
    repeat (40) step(0, 0, 1, 0);

    // R9: writes in the middle of channel 5 of both lanes
    bus_write(8'h30, 8'h40);
    cur_tag = "R9 midwrite";
    step(1, 1);
    repeat (35) step(0, 0);
    bus_write(8'h2B, 8'h10);
    bus_write(8'h22, 8'h00);
    repeat (NCH*BPC + 220) step(0, 0);

    @(negedge clk); @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule